// File: doc/BRIEF.md
# Transition-Triggered Standby Power Controller

This block guards a memory-and-logic array that should spend nearly all of its time powered down. It watches a bus of address and logic inputs and keeps the array in standby while that bus is quiet. When any watched bit changes, it raises a power-enable to the array. It then waits a fixed number of clocks for the array's combinational result to settle, captures that result in an output register and drops the power-enable on its own. The captured value stays on the output while the array is dark.

Standby is the resting state and needs no command. A chip-select input acts only as a veto. While it is low, the array is held off and any activity on the watched bus is discarded. When chip-select returns, nothing happens until the bus changes again. If the bus changes a second time while the array is still settling, the settle wait starts over, so the register only ever captures data that has been stable for the full wait. A wake-up therefore ends within SETTLE_CYC clocks of the last input change.

Top module: `zp_standby_ctrl`

## Requirements
- R1: During and after reset, `pwr_en` is 0, `busy` is 0 and `data_out` is all zeros. The watched-input value present at reset is not treated as a change, so the block stays in standby after reset is released.
- R2: With `chip_sel` high, a change on any single bit or any combination of bits of `watch_in` raises `pwr_en` at the next rising clock edge.
- R3: Once raised, `pwr_en` stays high for exactly SETTLE_CYC clock cycles (default 4) if the inputs do not change again. At the edge that ends that window, `arr_data` is captured into `data_out` and `pwr_en` falls.
- R4: While `watch_in` is unchanged, `pwr_en` stays 0 and `data_out` keeps its last captured value.
- R5: While `chip_sel` is low, `pwr_en` is 0 from the next edge on. A wake-up in progress is abandoned without a capture. Changes on `watch_in` cause no wake-up. Raising `chip_sel` again without a further input change causes no wake-up.
- R6: A change on `watch_in` while `pwr_en` is high restarts the settle wait. `pwr_en` then stays high for SETTLE_CYC cycles counted from the edge that saw the new change, and `data_out` captures the array output for the final input value.
- R7: `busy` is 1 in the cycle in which an accepted input change is visible and in every cycle in which `pwr_en` is 1. Otherwise it is 0.
- R8: `data_out` changes only at the edge that ends a completed settle window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_sel | input | 1 | High allows wake-ups; low forces standby |
| watch_in | input | IN_W | Watched address and logic inputs |
| arr_data | input | DATA_W | Combinational result from the array |
| pwr_en | output | 1 | Power-enable to the array |
| busy | output | 1 | High from an accepted change until standby |
| data_out | output | DATA_W | Registered array result |

## Verification
Two things can land on the same edge. An input change can arrive in the very cycle the settle counter reaches its last count. Separately, a chip-select drop can arrive mid-settle, in the same cycle as an input change. The bench provokes the first case by changing the inputs at several offsets inside the wake window, including the last cycle. It then requires that no capture happens at that edge, and that the window restarts and ends with the value for the newest input. For the second case, the bench drops chip-select together with a change and expects power off, no capture, and no wake-up once chip-select returns.

// File: rtl/zp_pkg.sv
package zp_pkg;

    typedef enum logic [0:0] {
        ZP_STANDBY = 1'b0,
        ZP_ACTIVE  = 1'b1
    } zp_phase_e;

    function automatic int unsigned zp_cnt_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/zp_change_detect.sv
module zp_change_detect #(
    parameter int unsigned IN_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [IN_W-1:0] watch_in,
    output logic            change_o
);

    typedef struct packed {
        logic [IN_W-1:0] prev;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [IN_W-1:0] bit_diff;

    // Per-bit comparison against the copy taken on the previous clock.
    for (genvar g = 0; g < IN_W; g++) begin : g_lane
        assign bit_diff[g] = watch_in[g] ^ st_q.prev[g];
    end

    always_comb begin
        st_d      = st_q;
        // The copy tracks the bus even while disabled, so activity during
        // a deselect is forgotten once chip select returns.
        st_d.prev = watch_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= watch_in;
        end else begin
            st_q <= st_d;
        end
    end

    assign change_o = enable & (|bit_diff);

    // A bus value differing from the previous cycle's is always reported.
    assert_change_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(rst_n) && (watch_in != $past(watch_in))) |-> change_o);

endmodule

// File: rtl/zp_settle_timer.sv
module zp_settle_timer #(
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    import zp_pkg::*;

    localparam int unsigned CNT_W = zp_cnt_width(SETTLE_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (run && (st_q.cnt != LAST)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = run & ~clear & (st_q.cnt == LAST);

    assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    assert_clear_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.cnt == '0));

endmodule

// File: rtl/zp_out_reg.sv
module zp_out_reg #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.val = d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

    assert_hold_without_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/zp_standby_ctrl.sv
module zp_standby_ctrl #(
    parameter int unsigned IN_W       = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned SETTLE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel,
    input  logic [IN_W-1:0]   watch_in,
    input  logic [DATA_W-1:0] arr_data,
    output logic              pwr_en,
    output logic              busy,
    output logic [DATA_W-1:0] data_out
);
    import zp_pkg::*;

    typedef struct packed {
        zp_phase_e phase;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic in_change;
    logic tmr_clear;
    logic tmr_done;
    logic cap_load;
    logic active;

    assign active = (st_q.phase == ZP_ACTIVE);

    zp_change_detect #(.IN_W(IN_W)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (chip_sel),
        .watch_in (watch_in),
        .change_o (in_change)
    );

    // Counter restarts on a new wake-up, on a change during settle,
    // and is held at zero whenever the array is off.
    assign tmr_clear = in_change | ~active;

    zp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .run   (active),
        .done  (tmr_done)
    );

    always_comb begin
        st_d     = st_q;
        cap_load = 1'b0;
        unique case (st_q.phase)
            ZP_STANDBY: begin
                if (in_change) begin
                    st_d.phase = ZP_ACTIVE;
                end
            end
            ZP_ACTIVE: begin
                if (!chip_sel) begin
                    st_d.phase = ZP_STANDBY;
                end else if (tmr_done) begin
                    cap_load   = 1'b1;
                    st_d.phase = ZP_STANDBY;
                end
            end
            default: st_d.phase = ZP_STANDBY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= ZP_STANDBY;
        end else begin
            st_q <= st_d;
        end
    end

    zp_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cap_load),
        .d     (arr_data),
        .q     (data_out)
    );

    assign pwr_en = active;
    assign busy   = active | in_change;

    assert_deselect_sleeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel |=> !pwr_en);

    assert_wake_on_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_change && !pwr_en) |=> pwr_en);

    assert_capture_ends_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_load |=> !pwr_en);

    assert_busy_covers_power_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> $past(busy));

    assert_quiet_stays_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && !in_change) |=> !pwr_en);

endmodule

// File: tb/zp_standby_ctrl_tb.sv
module zp_standby_ctrl_tb_top;

    localparam int unsigned IN_W   = 16;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned SETTLE = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chip_sel = 1'b1;
    logic [IN_W-1:0]   watch_in = 16'h1234;
    logic [DATA_W-1:0] arr_data;
    logic              pwr_en;
    logic              busy;
    logic [DATA_W-1:0] data_out;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;
    logic [DATA_W-1:0] exp_q = '0;

    always #4 clk = ~clk;

    function automatic logic [DATA_W-1:0] arr_fn(input logic [IN_W-1:0] x);
        return x[7:0] ^ {x[11:8], x[15:12]} ^ 8'h5A;
    endfunction

    // Array stand-in: a valid result only while powered.
    assign arr_data = pwr_en ? arr_fn(watch_in) : 8'h00;

    zp_standby_ctrl #(.IN_W(IN_W), .DATA_W(DATA_W), .SETTLE_CYC(SETTLE)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_sel (chip_sel),
        .watch_in (watch_in),
        .arr_data (arr_data),
        .pwr_en   (pwr_en),
        .busy     (busy),
        .data_out (data_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive a new value at a falling edge, then follow a full settle window.
    task automatic access(input logic [IN_W-1:0] v, input int unsigned redo_at);
        logic [IN_W-1:0] cur;
        cur = v;
        @(negedge clk);
        watch_in = cur;
        #1;
        chk(busy == 1'b1 && pwr_en == 1'b0, "R7 busy in detect cycle", {busy, pwr_en}, 2'b10);
        for (int i = 1; i <= SETTLE; i++) begin
            @(negedge clk);
            chk(pwr_en == 1'b1, "R3 power held", pwr_en, 1);
            chk(busy == 1'b1, "R7 busy while powered", busy, 1);
            chk(data_out == exp_q, "R8 no early capture", data_out, exp_q);
            if (redo_at == i) begin
                cur = cur ^ 16'h0101;
                watch_in = cur;
                for (int j = 1; j <= SETTLE; j++) begin
                    @(negedge clk);
                    chk(pwr_en == 1'b1, "R6 window restarted", pwr_en, 1);
                    chk(data_out == exp_q, "R6 no capture on restart", data_out, exp_q);
                end
                break;
            end
        end
        @(negedge clk);
        exp_q = arr_fn(cur);
        chk(pwr_en == 1'b0, "R3 power drops after window", pwr_en, 0);
        chk(busy == 1'b0, "R7 busy clears", busy, 0);
        chk(data_out == exp_q, redo_at != 0 ? "R6 final value captured" : "R3 captured value",
            data_out, exp_q);
    endtask

    task automatic idle(input int unsigned n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(pwr_en == 1'b0, tag, pwr_en, 0);
            chk(data_out == exp_q, tag, data_out, exp_q);
        end
    endtask

    initial begin
        void'($urandom(32'd7082));
        repeat (3) @(negedge clk);
        chk(pwr_en == 1'b0 && busy == 1'b0, "R1 outputs in reset", {pwr_en, busy}, 0);
        chk(data_out == '0, "R1 data cleared", data_out, 0);
        rst_n = 1'b1;
        idle(4, "R1 no wake after reset");
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);

        // Single-bit changes on each lane
        for (int b = 0; b < IN_W; b++) begin
            access(watch_in ^ (16'h1 << b), 0);
        end
        idle(10, "R4 quiet bus holds");

        // Restart at every offset, including the final settle cycle
        for (int k = 1; k <= SETTLE; k++) begin
            access(watch_in ^ 16'hF00F, k);
        end

        // Deselect mid-wake together with a change
        @(negedge clk);
        watch_in = watch_in ^ 16'h00F0;
        @(negedge clk);
        chk(pwr_en == 1'b1, "R2 woke", pwr_en, 1);
        chip_sel = 1'b0;
        watch_in = watch_in ^ 16'h0F00;
        @(negedge clk);
        chk(pwr_en == 1'b0, "R5 deselect forces standby", pwr_en, 0);
        chk(data_out == exp_q, "R5 no capture on deselect", data_out, exp_q);
        for (int i = 0; i < 6; i++) begin
            watch_in = 16'($urandom);
            @(negedge clk);
            chk(pwr_en == 1'b0, "R5 changes ignored while deselected", pwr_en, 0);
        end
        chip_sel = 1'b1;
        idle(5, "R5 no wake on reselect");
        access(watch_in ^ 16'h8001, 0);

        // Random mix
        for (int n = 0; n < 300; n++) begin
            logic [IN_W-1:0] v;
            v = 16'($urandom);
            if (v == watch_in) v[0] = ~v[0];
            access(v, ($urandom % 4 == 0) ? (1 + $urandom % SETTLE) : 0);
            if ($urandom % 5 == 0) idle(1 + $urandom % 3, "R4 random idle");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule